// File: doc/BRIEF.md
# Multi-Level Address Translation Walker

This block turns a 64-bit logical address into a real address by walking in-memory translation tables. Depending on the descriptor type, the walk starts at one of four levels: region-first, region-second, region-third or segment. It always ends at a page entry unless a large-frame segment entry ends it sooner. The block reads each 64-bit table entry through a single memory read port that has one outstanding request. At every step it checks validity, entry type and table bounds, and it collects write protection along the way.

The requester presents the address, an access kind and an address-space mode. The block takes the request only while it is idle. It chooses the descriptor from one of three control-register inputs and returns a single-cycle result. The result is either a page-aligned real address with read, write and execute permission, or a fault code together with an exception word that describes the failed access.

Top module: `xlat_walker`

## Requirements
- R1: After reset, `done`, `busy` and `mem_req` are low.
- R2: If `dat_en` is low, or the selected descriptor has bit 5 (real space) set, the result is the logical address with bits 11:0 cleared. No table is read, and before any mode masking all three permissions are granted.
- R3: Access kind encoding is 0 read, 1 store, 2 instruction fetch. Mode encoding is 0 primary, 1 (handled as primary), 2 secondary, 3 home. Primary uses `cr1` and home uses `cr13`. In secondary mode a fetch uses `cr1` and reports read and write as denied, while a data access uses `cr7` and reports execute as denied.
- R4: Descriptor bits 3:2 give the start level: 3 region-first, 2 region-second, 1 region-third, 0 segment. For start levels 2, 1 and 0, logical bits 63:53, 63:42 and 63:31 respectively must be zero, or fault 0x38 is raised. Next, the 2-bit index of the start level (address bits 63:62, 52:51, 41:40 or 30:29) must not exceed descriptor bits 1:0. Otherwise the level's fault is raised: 0x39 region-first, 0x3A region-second, 0x3B region-third, 0x10 segment.
- R5: An entry is read at its table origin (entry bits 63:12, or descriptor bits 63:12 at the start) plus the 11-bit index of its level times 8. The indices are bits 63:53, 52:42, 41:31 and 30:20 for levels 3 to 0. `mem_req` stays high with a stable, 8-byte-aligned `mem_addr` until `mem_valid`.
- R6: A fetched region or segment entry with bit 5 set raises the fault of its own level. Otherwise, if its bits 3:2 differ from the expected level, it raises 0x12. The invalid check takes precedence.
- R7: Before the walk leaves a region entry, the next level's 2-bit index must be at least entry bits 7:6 and at most entry bits 1:0. Otherwise the next level's fault is raised.
- R8: When `edat_en` is high and a segment entry has bit 10 set, the walk ends with the address {entry[63:20], logical[19:12], 12'h000}.
- R9: In all other cases the page entry sits at segment-entry bits 63:11 plus logical bits 19:12 times 8. If page-entry bit 10 is set the fault is 0x11. Otherwise, if bit 11 is set, the fault is 0x12. Otherwise the result is page-entry bits 63:12.
- R10: Bit 9 of a segment or page entry removes write permission, and so does bit 9 of a region entry when `edat_en` is high. A store without write permission raises fault 0x04.
- R11: On a fault, `exc_word` holds the page-aligned logical address ORed with 0x400 for a store or 0x800 otherwise, with 0x4 for fault 0x04, and with the space value (2 for a secondary data access, 3 for home, otherwise 0) in bits 1:0.
- R12: `req_valid` is ignored while `busy` is high. Each request produces exactly one `done` pulse, and the result outputs hold until the next pulse.
- R13: On a fault, `xlat_addr` and all permission outputs are zero. On success, `fault_code` and `exc_word` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a translation (taken only when idle) |
| req_vaddr | input | 64 | Logical address |
| req_kind | input | 2 | Access kind: 0 read, 1 store, 2 fetch |
| req_space | input | 2 | Mode: 0/1 primary, 2 secondary, 3 home |
| dat_en | input | 1 | Translation enable |
| edat_en | input | 1 | Enhanced translation enable |
| cr1 | input | 64 | Primary descriptor |
| cr7 | input | 64 | Secondary descriptor |
| cr13 | input | 64 | Home descriptor |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Table read request |
| mem_addr | output | 64 | Table entry address |
| mem_valid | input | 1 | Read data valid |
| mem_data | input | 64 | Table entry |
| done | output | 1 | Result pulse |
| fault | output | 1 | Translation failed |
| fault_code | output | 8 | Fault code |
| xlat_addr | output | 64 | Real address |
| perm_r | output | 1 | Read allowed |
| perm_w | output | 1 | Write allowed |
| perm_x | output | 1 | Execute allowed |
| exc_word | output | 64 | Exception word |

## Verification
Two pairs of checks can hit the same entry. The invalid bit and the type mismatch are tested on the same region or segment entry, and the invalid bit and the reserved bit are tested on the same page entry. Write-protection collection and the final store check can also fall in the cycle that returns the last entry. The random tables corrupt these entry bits on their own, so some entries carry two defects at once. The bench model applies the precedence from the requirements and compares the fault code it expects with the one reported. In addition, stray `req_valid` pulses are driven while a walk is in progress. The bench then checks that the result still belongs to the first request.

// File: rtl/xlat_walker.sv
`timescale 1ns/1ps
module xlat_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [63:0] req_vaddr,
  input  logic [1:0]  req_kind,
  input  logic [1:0]  req_space,
  input  logic        dat_en,
  input  logic        edat_en,
  input  logic [63:0] cr1,
  input  logic [63:0] cr7,
  input  logic [63:0] cr13,
  output logic        busy,
  output logic        mem_req,
  output logic [63:0] mem_addr,
  input  logic        mem_valid,
  input  logic [63:0] mem_data,
  output logic        done,
  output logic        fault,
  output logic [7:0]  fault_code,
  output logic [63:0] xlat_addr,
  output logic        perm_r,
  output logic        perm_w,
  output logic        perm_x,
  output logic [63:0] exc_word
);
  localparam logic [7:0] FC_PROT  = 8'h04;
  localparam logic [7:0] FC_SEG   = 8'h10;
  localparam logic [7:0] FC_PAGE  = 8'h11;
  localparam logic [7:0] FC_SPEC  = 8'h12;
  localparam logic [7:0] FC_ATYPE = 8'h38;
  localparam logic [7:0] FC_RG1   = 8'h39;
  localparam logic [7:0] FC_RG2   = 8'h3A;
  localparam logic [7:0] FC_RG3   = 8'h3B;

  function automatic logic [7:0] lvl_code(input logic [1:0] l);
    case (l)
      2'd0:    lvl_code = FC_SEG;
      2'd1:    lvl_code = FC_RG3;
      2'd2:    lvl_code = FC_RG2;
      default: lvl_code = FC_RG1;
    endcase
  endfunction

  function automatic logic [13:0] ent_off(input logic [1:0] l, input logic [63:0] v);
    case (l)
      2'd0:    ent_off = {v[30:20], 3'b000};
      2'd1:    ent_off = {v[41:31], 3'b000};
      2'd2:    ent_off = {v[52:42], 3'b000};
      default: ent_off = {v[63:53], 3'b000};
    endcase
  endfunction

  function automatic logic [1:0] next_idx(input logic [1:0] l, input logic [63:0] v);
    case (l)
      2'd1:    next_idx = v[30:29];
      2'd2:    next_idx = v[41:40];
      default: next_idx = v[52:51];
    endcase
  endfunction

  logic        fetching, pg, wr_q, secf_q, secd_q;
  logic [1:0]  lvl, kind_q, sp_q;
  logic [63:0] va_q, addr_q;

  wire        sec_in  = (req_space == 2'd2);
  wire        secf_in = sec_in && (req_kind == 2'd2);
  wire        secd_in = sec_in && (req_kind != 2'd2);
  wire [63:0] asce    = (req_space == 2'd3) ? cr13 : secd_in ? cr7 : cr1;
  wire [63:0] va_in   = {req_vaddr[63:12], 12'h000};
  wire [1:0]  sp_in   = secd_in ? 2'd2 : (req_space == 2'd3) ? 2'd3 : 2'd0;

  wire [63:0] va_e   = fetching ? va_q   : va_in;
  wire [1:0]  kind_e = fetching ? kind_q : req_kind;
  wire [1:0]  sp_e   = fetching ? sp_q   : sp_in;
  wire        secf_e = fetching ? secf_q : secf_in;
  wire        secd_e = fetching ? secd_q : secd_in;
  wire [1:0]  nidx   = next_idx(lvl, va_q);
  wire [1:0]  lvl_dn = lvl - 2'd1;

  logic        fin, ff, fw, go, npg;
  logic [7:0]  fc;
  logic [63:0] fa, na;
  logic [1:0]  nl;

  always_comb begin
    fin = 1'b0; ff = 1'b0; fc = 8'h00; fa = 64'd0; fw = wr_q;
    go = 1'b0; npg = 1'b0; nl = lvl; na = 64'd0;
    if (!fetching) begin
      if (req_valid) begin
        fw = 1'b1;
        if (!dat_en || asce[5]) begin
          fin = 1'b1; fa = va_in;
        end else begin
          case (asce[3:2])
            2'd3: if (va_in[63:62] > asce[1:0]) begin fin = 1'b1; ff = 1'b1; fc = FC_RG1; end
            2'd2: if (|va_in[63:53]) begin fin = 1'b1; ff = 1'b1; fc = FC_ATYPE; end
                  else if (va_in[52:51] > asce[1:0]) begin fin = 1'b1; ff = 1'b1; fc = FC_RG2; end
            2'd1: if (|va_in[63:42]) begin fin = 1'b1; ff = 1'b1; fc = FC_ATYPE; end
                  else if (va_in[41:40] > asce[1:0]) begin fin = 1'b1; ff = 1'b1; fc = FC_RG3; end
            default: if (|va_in[63:31]) begin fin = 1'b1; ff = 1'b1; fc = FC_ATYPE; end
                  else if (va_in[30:29] > asce[1:0]) begin fin = 1'b1; ff = 1'b1; fc = FC_SEG; end
          endcase
          if (!fin) begin
            go = 1'b1; nl = asce[3:2];
            na = {asce[63:12], 12'h000} + {50'd0, ent_off(asce[3:2], va_in)};
          end
        end
      end
    end else if (mem_valid) begin
      if (pg) begin
        if (mem_data[10]) begin fin = 1'b1; ff = 1'b1; fc = FC_PAGE; end
        else if (mem_data[11]) begin fin = 1'b1; ff = 1'b1; fc = FC_SPEC; end
        else begin fin = 1'b1; fw = wr_q & ~mem_data[9]; fa = {mem_data[63:12], 12'h000}; end
      end else if (mem_data[5]) begin
        fin = 1'b1; ff = 1'b1; fc = lvl_code(lvl);
      end else if (mem_data[3:2] != lvl) begin
        fin = 1'b1; ff = 1'b1; fc = FC_SPEC;
      end else if (lvl == 2'd0) begin
        fw = wr_q & ~mem_data[9];
        if (edat_en && mem_data[10]) begin
          fin = 1'b1; fa = {mem_data[63:20], va_q[19:0]};
        end else begin
          go = 1'b1; npg = 1'b1; nl = 2'd0;
          na = {mem_data[63:11], 11'd0} + {53'd0, va_q[19:12], 3'b000};
        end
      end else if (nidx < mem_data[7:6] || nidx > mem_data[1:0]) begin
        fin = 1'b1; ff = 1'b1; fc = lvl_code(lvl_dn);
      end else begin
        fw = wr_q & ~(edat_en & mem_data[9]);
        go = 1'b1; nl = lvl_dn;
        na = {mem_data[63:12], 12'h000} + {50'd0, ent_off(lvl_dn, va_q)};
      end
    end
    if (fin && !ff && kind_e == 2'd1 && !fw) begin ff = 1'b1; fc = FC_PROT; end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetching <= 1'b0; pg <= 1'b0; wr_q <= 1'b0; secf_q <= 1'b0; secd_q <= 1'b0;
      lvl <= 2'd0; kind_q <= 2'd0; sp_q <= 2'd0; va_q <= 64'd0; addr_q <= 64'd0;
      done <= 1'b0; fault <= 1'b0; fault_code <= 8'h00; xlat_addr <= 64'd0;
      perm_r <= 1'b0; perm_w <= 1'b0; perm_x <= 1'b0; exc_word <= 64'd0;
    end else begin
      done <= fin;
      if (!fetching && req_valid) begin
        va_q <= va_in; kind_q <= req_kind; sp_q <= sp_in;
        secf_q <= secf_in; secd_q <= secd_in;
      end
      if (go) begin
        fetching <= 1'b1; pg <= npg; lvl <= nl; addr_q <= na; wr_q <= fw;
      end else if (fin) begin
        fetching <= 1'b0;
      end
      if (fin) begin
        fault      <= ff;
        fault_code <= fc;
        xlat_addr  <= ff ? 64'd0 : fa;
        perm_r     <= !ff && !secf_e;
        perm_w     <= !ff && fw && !secf_e;
        perm_x     <= !ff && !secd_e;
        exc_word   <= ff ? {va_e[63:12], kind_e != 2'd1, kind_e == 2'd1, 7'd0, fc == FC_PROT, sp_e}
                         : 64'd0;
      end
    end
  end

  assign busy     = fetching;
  assign mem_req  = fetching;
  assign mem_addr = addr_q;

  logic unused_bits;
  assign unused_bits = ^{asce[11:6], asce[4], mem_data[8], mem_data[4], req_vaddr[11:0]};

  // R5
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_valid |=> mem_req && $stable(mem_addr));
  // R5
  mem_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[2:0] == 3'd0);
  // R12
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);
  // R10
  store_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fault && kind_q == 2'd1 |-> perm_w);
  // R11
  exc_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault |-> exc_word[11] != exc_word[10]);
  // R13
  page_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fault |-> xlat_addr[11:0] == 12'h000 && fault_code == 8'h00);
endmodule

// File: tb/sim_xlat_walker.sv
`timescale 1ns/1ps
module sim_xlat_walker;
  logic        clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0;
  logic [63:0] req_vaddr = 64'd0;
  logic [1:0]  req_kind = 2'd0, req_space = 2'd0;
  logic        dat_en = 1'b0, edat_en = 1'b0;
  logic [63:0] cr1 = 64'd0, cr7 = 64'd0, cr13 = 64'd0;
  logic        busy, mem_req, mem_valid = 1'b0;
  logic [63:0] mem_addr, mem_data = 64'd0;
  logic        done, fault, perm_r, perm_w, perm_x;
  logic [7:0]  fault_code;
  logic [63:0] xlat_addr, exc_word;

  int checks = 0, fails = 0;
  logic [63:0] mem [logic [63:0]];

  always #4 clk = ~clk;

  xlat_walker u0 (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_kind(req_kind), .req_space(req_space), .dat_en(dat_en), .edat_en(edat_en),
    .cr1(cr1), .cr7(cr7), .cr13(cr13), .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_valid(mem_valid), .mem_data(mem_data), .done(done), .fault(fault),
    .fault_code(fault_code), .xlat_addr(xlat_addr), .perm_r(perm_r), .perm_w(perm_w),
    .perm_x(perm_x), .exc_word(exc_word));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  function automatic logic [63:0] mem_rd(input logic [63:0] a);
    if (mem.exists(a)) return mem[a];
    return {a[31:0] ^ 32'h9E3779B9, a[63:32] ^ 32'h7F4A7C15};
  endfunction

  function automatic logic [63:0] eoff(input int lv, input logic [63:0] va);
    return (va >> (17 + 11 * lv)) & 64'h3FF8;
  endfunction

  function automatic logic [7:0] lvcode(input int lv);
    case (lv)
      0: return 8'h10;
      1: return 8'h3B;
      2: return 8'h3A;
      default: return 8'h39;
    endcase
  endfunction

  function automatic string code_tag(input logic [7:0] c);
    case (c)
      8'h00: return "R2/R8/R9";
      8'h04: return "R10";
      8'h38: return "R4";
      8'h11: return "R9";
      default: return "R4/R6/R7";
    endcase
  endfunction

  task automatic ref_walk(input logic [63:0] vin, input logic [1:0] kind, input logic [1:0] mode,
      input logic dat, input logic edat, input logic [63:0] c1, input logic [63:0] c7, input logic [63:0] c13,
      output logic [7:0] code, output logic [63:0] ra, output logic [2:0] rwx, output logic [63:0] word);
    logic [63:0] va, asce, o, e, p;
    logic [1:0] sp;
    logic w;
    bit secf, secd, stop;
    int lv;
    logic [63:0] idx;
    va = {vin[63:12], 12'h000};
    secf = (mode == 2) && (kind == 2);
    secd = (mode == 2) && (kind != 2);
    asce = (mode == 3) ? c13 : secd ? c7 : c1;
    sp = secd ? 2'd2 : (mode == 3) ? 2'd3 : 2'd0;
    w = 1'b1; code = 8'h00; ra = va;
    if (dat && !asce[5]) begin
      lv = int'(asce[3:2]);
      if ((lv == 0 && (va >> 31) != 0) || (lv == 1 && (va >> 42) != 0) || (lv == 2 && (va >> 53) != 0))
        code = 8'h38;
      else if (((va >> (29 + 11 * lv)) & 3) > {62'd0, asce[1:0]})
        code = lvcode(lv);
      else begin
        o = {asce[63:12], 12'h000};
        stop = 0;
        while (!stop) begin
          e = mem_rd(o + eoff(lv, va));
          stop = 1;
          if (e[5]) code = lvcode(lv);
          else if (int'(e[3:2]) != lv) code = 8'h12;
          else if (lv == 0) begin
            if (e[9]) w = 1'b0;
            if (edat && e[10]) ra = {e[63:20], va[19:0]};
            else begin
              p = mem_rd({e[63:11], 11'd0} + {53'd0, va[19:12], 3'd0});
              if (p[10]) code = 8'h11;
              else if (p[11]) code = 8'h12;
              else begin
                if (p[9]) w = 1'b0;
                ra = {p[63:12], 12'h000};
              end
            end
          end else begin
            idx = (va >> (29 + 11 * (lv - 1))) & 3;
            if (idx < {62'd0, e[7:6]} || idx > {62'd0, e[1:0]}) code = lvcode(lv - 1);
            else begin
              if (edat && e[9]) w = 1'b0;
              o = {e[63:12], 12'h000};
              lv--;
              stop = 0;
            end
          end
        end
      end
      if (code == 8'h00 && kind == 2'd1 && !w) code = 8'h04;
    end
    if (code != 8'h00) begin
      ra = 64'd0; rwx = 3'b000;
      word = va | ((kind == 2'd1) ? 64'h400 : 64'h800) | ((code == 8'h04) ? 64'h4 : 64'h0) | {62'd0, sp};
    end else begin
      rwx = {!secf, w && !secf, !secd};
      word = 64'd0;
    end
  endtask

  task automatic run_one(input logic [63:0] va, input logic [63:0] c1, input logic [63:0] c7,
      input logic [63:0] c13, input logic [1:0] kind, input logic [1:0] mode, input logic dat,
      input logic edat, input bit inj);
    logic [7:0] ecode; logic [63:0] ea, ew; logic [2:0] erwx;
    int n; bit did;
    string t;
    ref_walk(va, kind, mode, dat, edat, c1, c7, c13, ecode, ea, erwx, ew);
    @(negedge clk);
    req_vaddr = va; req_kind = kind; req_space = mode; dat_en = dat; edat_en = edat;
    cr1 = c1; cr7 = c7; cr13 = c13; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0; did = 0;
    while (!done && n < 300) begin
      @(negedge clk);
      n++;
      req_valid = 1'b0;
      if (inj && !did && busy) begin
        req_vaddr = rnd64(); req_kind = 2'd1; req_space = 2'd3; cr13 = 64'h20;
        req_valid = 1'b1; did = 1;
      end
    end
    req_valid = 1'b0;
    t = inj ? "R12" : code_tag(ecode);
    chk(done, {"R12 done pulse ", t}, {63'd0, done}, 64'd1);
    chk(fault_code == ecode && fault == (ecode != 0), {"code ", t}, {55'd0, fault, fault_code}, {55'd0, ecode != 0, ecode});
    chk(xlat_addr == ea, {"addr R13 ", t}, xlat_addr, ea);
    chk({perm_r, perm_w, perm_x} == erwx, "perms R3/R13", {61'd0, perm_r, perm_w, perm_x}, {61'd0, erwx});
    chk(exc_word == ew, "exc word R11", exc_word, ew);
  endtask

  task automatic make_case(output logic [63:0] va, output logic [63:0] c1, output logic [63:0] c7,
      output logic [63:0] c13, output logic [1:0] kind, output logic [1:0] mode,
      output logic dat, output logic edat);
    logic [63:0] asce, o, nxt, addr, e, pto;
    logic [1:0] top, tl, tf, len, ty;
    int lv;
    mem.delete();
    mode = 2'($urandom % 4); kind = 2'($urandom % 3);
    dat = ($urandom % 12) != 0; edat = 1'($urandom % 2);
    c1 = rnd64(); c7 = rnd64(); c13 = rnd64();
    top = 2'($urandom % 4);
    tl = (($urandom % 5) == 0) ? 2'($urandom % 4) : 2'd3;
    o = {rnd64() >> 12, 12'h000};
    asce = o | (($urandom % 16) == 0 ? 64'h20 : 64'h0) | {60'd0, top, tl};
    va = rnd64();
    if (($urandom % 10) != 0) begin
      if (top == 0) va = va & 64'h7FFF_FFFF;
      if (top == 1) va = va & 64'h3FF_FFFF_FFFF;
      if (top == 2) va = va & 64'h1F_FFFF_FFFF_FFFF;
    end
    lv = int'(top);
    while (lv > 0) begin
      addr = o + eoff(lv, va);
      nxt = {rnd64() >> 12, 12'h000};
      tf  = (($urandom % 12) == 0) ? 2'($urandom % 4) : 2'd0;
      len = (($urandom % 12) == 0) ? 2'($urandom % 4) : 2'd3;
      ty  = (($urandom % 16) == 0) ? 2'($urandom % 4) : 2'(lv);
      e = nxt | (($urandom % 4) == 0 ? 64'h200 : 64'h0) | {56'd0, tf, (($urandom % 16) == 0), 1'b0, ty, len};
      mem[addr] = e;
      o = nxt; lv--;
    end
    addr = o + eoff(0, va);
    pto = {rnd64() >> 11, 11'd0};
    ty  = (($urandom % 16) == 0) ? 2'($urandom % 4) : 2'd0;
    e = pto | (($urandom % 3) == 0 ? 64'h400 : 64'h0) | (($urandom % 4) == 0 ? 64'h200 : 64'h0)
            | (($urandom % 14) == 0 ? 64'h20 : 64'h0) | {60'd0, ty, 2'd0};
    mem[addr] = e;
    mem[pto + {53'd0, va[19:12], 3'd0}] = {rnd64() >> 12, 12'h000}
            | (($urandom % 10) == 0 ? 64'h800 : 64'h0) | (($urandom % 10) == 0 ? 64'h400 : 64'h0)
            | (($urandom % 4) == 0 ? 64'h200 : 64'h0);
    case ((mode == 3) ? 0 : (mode == 2 && kind != 2) ? 1 : 2)
      0: c13 = asce;
      1: c7 = asce;
      default: c1 = asce;
    endcase
  endtask

  // memory responder with R5 address stability and alignment checks
  initial begin
    logic [63:0] raddr;
    bit seen;
    int dly;
    seen = 0; dly = 0; raddr = 64'd0;
    forever begin
      @(negedge clk);
      if (mem_valid) begin mem_valid = 1'b0; seen = 0; end
      if (mem_req && !seen) begin seen = 1; raddr = mem_addr; dly = int'($urandom % 3); end
      if (mem_req && seen) begin
        if (dly == 0) begin
          chk(mem_addr == raddr && mem_addr[2:0] == 3'd0, "R5 mem addr held/aligned", mem_addr, raddr);
          mem_data = mem_rd(mem_addr);
          mem_valid = 1'b1;
        end else dly--;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] va, c1, c7, c13;
    logic [1:0] kind, mode;
    logic dat, edat;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!done && !busy && !mem_req, "R1 reset state", {61'd0, done, busy, mem_req}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !busy && !mem_req, "R1 after reset release", {61'd0, done, busy, mem_req}, 64'd0);
    // R2 translation off
    run_one(64'h1234_5678_9ABC_DEF0, 64'h0, 64'h0, 64'h0, 2'd1, 2'd0, 1'b0, 1'b0, 0);
    // R2 + R3 real-space descriptor, secondary fetch
    run_one(64'hFFFF_0000_1111_2FFF, 64'h20, 64'h0, 64'h0, 2'd2, 2'd2, 1'b1, 1'b0, 0);
    // R3 secondary data uses cr7 real space
    run_one(64'h0000_0000_0040_3123, 64'h0, 64'h20, 64'h0, 2'd0, 2'd2, 1'b1, 1'b0, 0);
    // R4 segment descriptor with high address bits set
    run_one(64'h0000_0100_0000_0000, 64'h0000_0000_0010_0003, 64'h0, 64'h0, 2'd0, 2'd0, 1'b1, 1'b0, 0);
    // R4 region-first length exceeded, home mode
    run_one(64'hC000_0000_0000_0000, 64'h0, 64'h0, 64'h0000_0000_0020_000D, 2'd1, 2'd3, 1'b1, 1'b0, 0);
    // R4 segment length exceeded
    run_one(64'h0000_0000_6000_0000, 64'h0000_0000_0030_0001, 64'h0, 64'h0, 2'd0, 2'd0, 1'b1, 1'b0, 0);
    for (int i = 0; i < 500; i++) begin
      make_case(va, c1, c7, c13, kind, mode, dat, edat);
      run_one(va, c1, c7, c13, kind, mode, dat, edat, ($urandom % 4) == 0);
    end
    repeat (4) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule